// File: doc/BRIEF.md
# Dual-Mode Pixel Bus Capture

This block sits at the front of a display transmitter. A graphics controller feeds it pixel data, a data-enable and two syncs over a parallel bus. The block turns that into one full RGB pixel per clock with aligned DE and sync flags and a valid strobe. The bus runs in one of two ways:

- **Wide mode:** the whole 24-bit word arrives at once and is latched on one selected clock edge.
- **Narrow mode:** the pixel comes in two 12-bit halves on opposite clock edges, and the block joins them back into one pixel.

The selected edge sets which half counts as the first one. Downstream logic sees the same registered pixel interface in either mode.

Each sync can be forced low by its own enable. A transmit-disable input blanks the pixel stream. All outputs update on the rising clock edge. Mode and gating inputs are sampled at the rising edge that loads the output register. They are not resynchronised, so a change takes effect on the very next output.

Top module: `pixel_capture`

## Requirements
- R1: While `rstN` is low, `pixOut` is zero and `deOut`, `hsyncOut`, `vsyncOut` and `pixValid` are low.
- R2: With `busWide`=1 and `edgeRise`=1, the word on `inData` at a rising edge appears on `pixOut` after the next rising edge. Red is bits 23:16, green is bits 15:8 and blue is bits 7:0, so the word passes through unchanged.
- R3: With `busWide`=1 and `edgeRise`=0, the word on `inData` at a falling edge appears on `pixOut` after the rising edge that follows it.
- R4: With `busWide`=0 and `edgeRise`=1, `inData[11:0]` at a rising edge carries {G[3:0],B[7:0]}. `inData[11:0]` at the following falling edge carries {R[7:0],G[7:4]}. After the next rising edge, `pixOut` equals {second half, first half}.
- R5: With `busWide`=0 and `edgeRise`=0, the first half {G[3:0],B[7:0]} is taken at a falling edge and the second half {R[7:0],G[7:4]} at the following rising edge. The joined pixel appears after the rising edge one clock later.
- R6: In narrow mode, `inData[23:12]` has no effect on any output.
- R7: `deOut`, `hsyncOut` and `vsyncOut` come from the same capture as the first half of the pixel, which in wide mode is the single capture. They appear in the same cycle as that pixel.
- R8: When `hsyncEn` is 0 at a rising edge, `hsyncOut` is low after that edge. When it is 1, the captured horizontal sync passes.
- R9: When `vsyncEn` is 0 at a rising edge, `vsyncOut` is low after that edge. When it is 1, the captured vertical sync passes.
- R10: When `txDisable` is 1 at a rising edge, `pixOut` is zero and `pixValid` and `deOut` are low after that edge.
- R11: `pixValid` is first high after the third rising edge following reset release. From then on it is high after every rising edge at which `txDisable` is 0. `deOut` is never high while `pixValid` is low.
- R12: Changing `busWide` or `edgeRise` between any two rising edges takes effect on the next output with no lost or stale cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock; both edges capture |
| rstN | input | 1 | Asynchronous active-low reset |
| busWide | input | 1 | 1: 24-bit single-edge, 0: 12-bit dual-edge |
| edgeRise | input | 1 | Capture or primary edge: 1 rising, 0 falling |
| hsyncEn | input | 1 | 0 forces horizontal sync output low |
| vsyncEn | input | 1 | 0 forces vertical sync output low |
| txDisable | input | 1 | Blanks pixel, DE and valid |
| inData | input | 24 | Pixel bus from the controller |
| inDe | input | 1 | Data enable from the controller |
| inHsync | input | 1 | Horizontal sync from the controller |
| inVsync | input | 1 | Vertical sync from the controller |
| pixOut | output | 24 | Assembled pixel {R,G,B} |
| deOut | output | 1 | Registered data enable |
| hsyncOut | output | 1 | Registered, gated horizontal sync |
| vsyncOut | output | 1 | Registered, gated vertical sync |
| pixValid | output | 1 | Output pixel is valid this cycle |

## Verification
The bench sweeps all sixteen combinations of width, edge and sync enables with random bus words. It drives a different word before every rising and every falling edge, so swapping the halves or reading the wrong edge gives a visibly wrong pixel. The mistakes it targets are these:

- Falling-primary narrow mode reading the first half one clock late. This would pair the half-pixel of the next pixel with the current one.
- Control flags taken from the second capture instead of the first, which would skew DE against its pixel.
- The unused upper bits in narrow mode leaking into the output.

A final phase changes mode every cycle to catch any hidden pipeline state. The bench also checks the disable path and the warm-up of the valid strobe after reset. A blanking flaw would show up as DE or valid held high, or as stale pixel data while disabled.

// File: rtl/pixcap_pkg.sv
package pixcap_pkg;

  // Strobes from control to datapath, sampled at the output rising edge.
  typedef struct packed {
    logic wide;         // 1: whole word on one edge
    logic primaryRise;  // 1: rising edge is the (first) capture edge
    logic hsEn;         // pass horizontal sync
    logic vsEn;         // pass vertical sync
    logic blank;        // zero pixel, drop DE and valid
    logic warm;         // capture registers hold post-reset data
  } capCtrl_t;

endpackage

// File: rtl/pixcap_ctrl.sv
module pixcap_ctrl
  import pixcap_pkg::*;
#(
  parameter int WARMUP = 2
) (
  input  logic     clk,
  input  logic     rstN,
  input  logic     busWide,
  input  logic     edgeRise,
  input  logic     hsyncEn,
  input  logic     vsyncEn,
  input  logic     txDisable,
  output capCtrl_t ctrl
);

  localparam int CW = $clog2(WARMUP + 1);
  localparam logic [CW-1:0] WARM_LAST = CW'(WARMUP);

  logic [CW-1:0] warmCnt;

  // Counts rising edges since reset until every capture register has data.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      warmCnt <= '0;
    end else if (warmCnt != WARM_LAST) begin
      warmCnt <= warmCnt + 1'b1;
    end
  end

  always_comb begin
    ctrl.wide        = busWide;
    ctrl.primaryRise = edgeRise;
    ctrl.hsEn        = hsyncEn;
    ctrl.vsEn        = vsyncEn;
    ctrl.blank       = txDisable;
    ctrl.warm        = (warmCnt == WARM_LAST);
  end

endmodule

// File: rtl/pixcap_datapath.sv
module pixcap_datapath
  import pixcap_pkg::*;
#(
  parameter int PIX_W = 24
) (
  input  logic             clk,
  input  logic             rstN,
  input  capCtrl_t         ctrl,
  input  logic [PIX_W-1:0] inData,
  input  logic             inDe,
  input  logic             inHsync,
  input  logic             inVsync,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             pixValid
);

  localparam int HALF_W = PIX_W / 2;
  localparam int WORD_W = PIX_W + 3;
  localparam int DE_B   = PIX_W;
  localparam int HS_B   = PIX_W + 1;
  localparam int VS_B   = PIX_W + 2;

  logic [WORD_W-1:0] busWord;
  logic [WORD_W-1:0] riseWord;
  logic [WORD_W-1:0] fallWord;
  logic [WORD_W-1:0] holdWord;

  assign busWord = {inVsync, inHsync, inDe, inData};

  // One capture register per clock edge.
  for (genvar e = 0; e < 2; e++) begin : g_cap
    if (e == 0) begin : g_rise
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) riseWord <= '0;
        else       riseWord <= busWord;
      end
    end else begin : g_fall
      always_ff @(negedge clk or negedge rstN) begin
        if (!rstN) fallWord <= '0;
        else       fallWord <= busWord;
      end
    end
  end

  // Keeps the falling-edge half one clock longer, for falling-primary pairing.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) holdWord <= '0;
    else       holdWord <= fallWord;
  end

  logic [PIX_W-1:0] pixNext;
  logic [2:0]       flagNext;  // {vs, hs, de}
  logic [WORD_W-1:0] firstWord;

  always_comb begin
    if (ctrl.wide) begin
      firstWord = ctrl.primaryRise ? riseWord : fallWord;
      pixNext   = firstWord[PIX_W-1:0];
    end else if (ctrl.primaryRise) begin
      firstWord = riseWord;
      pixNext   = {fallWord[HALF_W-1:0], riseWord[HALF_W-1:0]};
    end else begin
      firstWord = holdWord;
      pixNext   = {riseWord[HALF_W-1:0], holdWord[HALF_W-1:0]};
    end
    flagNext = {firstWord[VS_B], firstWord[HS_B], firstWord[DE_B]};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pixOut   <= '0;
      deOut    <= 1'b0;
      hsyncOut <= 1'b0;
      vsyncOut <= 1'b0;
      pixValid <= 1'b0;
    end else begin
      pixOut   <= ctrl.blank ? '0 : pixNext;
      deOut    <= ~ctrl.blank & ctrl.warm & flagNext[0];
      hsyncOut <= ctrl.hsEn & flagNext[1];
      vsyncOut <= ctrl.vsEn & flagNext[2];
      pixValid <= ~ctrl.blank & ctrl.warm;
    end
  end

endmodule

// File: rtl/pixel_capture.sv
module pixel_capture
  import pixcap_pkg::*;
#(
  parameter int PIX_W  = 24,
  parameter int WARMUP = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             busWide,
  input  logic             edgeRise,
  input  logic             hsyncEn,
  input  logic             vsyncEn,
  input  logic             txDisable,
  input  logic [PIX_W-1:0] inData,
  input  logic             inDe,
  input  logic             inHsync,
  input  logic             inVsync,
  output logic [PIX_W-1:0] pixOut,
  output logic             deOut,
  output logic             hsyncOut,
  output logic             vsyncOut,
  output logic             pixValid
);

  capCtrl_t ctrl;

  pixcap_ctrl #(.WARMUP(WARMUP)) u_ctrl (
    .clk(clk), .rstN(rstN), .busWide(busWide), .edgeRise(edgeRise),
    .hsyncEn(hsyncEn), .vsyncEn(vsyncEn), .txDisable(txDisable), .ctrl(ctrl)
  );

  pixcap_datapath #(.PIX_W(PIX_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctrl(ctrl), .inData(inData), .inDe(inDe),
    .inHsync(inHsync), .inVsync(inVsync), .pixOut(pixOut), .deOut(deOut),
    .hsyncOut(hsyncOut), .vsyncOut(vsyncOut), .pixValid(pixValid)
  );

endmodule

// File: rtl/pixel_capture_chk.sv
module pixel_capture_chk #(
  parameter int PIX_W = 24
) (
  input logic             clk,
  input logic             rstN,
  input logic             busWide,
  input logic             edgeRise,
  input logic             hsyncEn,
  input logic             vsyncEn,
  input logic             txDisable,
  input logic [PIX_W-1:0] inData,
  input logic [PIX_W-1:0] pixOut,
  input logic             deOut,
  input logic             hsyncOut,
  input logic             vsyncOut,
  input logic             pixValid
);

  localparam int HALF_W = PIX_W / 2;

  p_wide_rise_r2: assert property (@(posedge clk) disable iff (!rstN)
    busWide && edgeRise && !txDisable |=> !pixValid || pixOut == $past(inData, 2));

  p_narrow_low_half_r4: assert property (@(posedge clk) disable iff (!rstN)
    !busWide && edgeRise && !txDisable |=>
      !pixValid || pixOut[HALF_W-1:0] == $past(inData[HALF_W-1:0], 2));

  p_hs_gate_r8: assert property (@(posedge clk) disable iff (!rstN)
    !hsyncEn |=> !hsyncOut);

  p_vs_gate_r9: assert property (@(posedge clk) disable iff (!rstN)
    !vsyncEn |=> !vsyncOut);

  p_blank_quiet_r10: assert property (@(posedge clk) disable iff (!rstN)
    txDisable |=> !pixValid && !deOut && pixOut == '0);

  p_de_needs_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    deOut |-> pixValid);

endmodule

bind pixel_capture pixel_capture_chk #(.PIX_W(PIX_W)) u_chk (
  .clk(clk), .rstN(rstN), .busWide(busWide), .edgeRise(edgeRise),
  .hsyncEn(hsyncEn), .vsyncEn(vsyncEn), .txDisable(txDisable),
  .inData(inData), .pixOut(pixOut), .deOut(deOut), .hsyncOut(hsyncOut),
  .vsyncOut(vsyncOut), .pixValid(pixValid)
);

// File: tb/test_pixel_capture.sv
module test_pixel_capture;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        busWide = 1'b1, edgeRise = 1'b1, hsyncEn = 1'b1, vsyncEn = 1'b1;
  logic        txDisable = 1'b0;
  logic [23:0] inData = '0;
  logic        inDe = 1'b0, inHsync = 1'b0, inVsync = 1'b0;
  logic [23:0] pixOut;
  logic        deOut, hsyncOut, vsyncOut, pixValid;

  int nTests = 0;
  int nFail  = 0;
  bit finished = 0;

  always #10 clk = ~clk;  // 50 MHz

  pixel_capture i_pixel_capture (
    .clk(clk), .rstN(rstN), .busWide(busWide), .edgeRise(edgeRise),
    .hsyncEn(hsyncEn), .vsyncEn(vsyncEn), .txDisable(txDisable),
    .inData(inData), .inDe(inDe), .inHsync(inHsync), .inVsync(inVsync),
    .pixOut(pixOut), .deOut(deOut), .hsyncOut(hsyncOut),
    .vsyncOut(vsyncOut), .pixValid(pixValid)
  );

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nTests++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h at %0t", tag, act, exp, $time);
    end
  endtask

  // Bus word layout used by the bench: {vsync, hsync, de, data[23:0]}.
  task automatic driveWord(input logic [26:0] w);
    inData  = w[23:0];
    inDe    = w[24];
    inHsync = w[25];
    inVsync = w[26];
  endtask

  function automatic logic [26:0] rndWord();
    return {$urandom_range(7, 0), 24'($urandom())};
  endfunction

  // History of driven words: rH = word before edge k-1, fH = word before the
  // falling edge between k-1 and k, ffH = the falling-edge word one clock earlier.
  logic [26:0] rH = '0, fH = '0, ffH = '0, curRise = '0;
  int k = 0;

  // Called at rising edge + 5: check edge k, then drive the next two half-cycles.
  task automatic stepCycle(input int phase);
    logic [26:0] first;
    logic [23:0] pix;
    logic [26:0] newFall;
    string pixTag;
    if (busWide) begin
      first  = edgeRise ? rH : fH;
      pix    = first[23:0];
      pixTag = edgeRise ? "R2" : "R3";
    end else if (edgeRise) begin
      first  = rH;
      pix    = {fH[11:0], rH[11:0]};
      pixTag = "R4 R6";
    end else begin
      first  = ffH;
      pix    = {rH[11:0], ffH[11:0]};
      pixTag = "R5 R6";
    end
    if (phase == 1) pixTag = "R12";
    if (txDisable) begin
      chk("R10 pixel", pixOut, 0);
      chk("R10 de", deOut, 0);
      chk("R10 valid", pixValid, 0);
    end else begin
      chk(pixTag, pixOut, pix);
      chk("R7 de", deOut, (k >= 3) ? first[24] : 1'b0);
      chk("R11 valid", pixValid, (k >= 3));
    end
    chk("R7 R8 hsync", hsyncOut, hsyncEn & first[25]);
    chk("R7 R9 vsync", vsyncOut, vsyncEn & first[26]);
    newFall = rndWord();
    driveWord(newFall);
    ffH = fH;
    fH  = newFall;
    rH  = curRise;
  endtask

  task automatic driveRise(input logic [3:0] cfg, input bit dis);
    curRise = rndWord();
    driveWord(curRise);
    busWide   = cfg[0];
    edgeRise  = cfg[1];
    hsyncEn   = cfg[2];
    vsyncEn   = cfg[3];
    txDisable = dis;
  endtask

  initial begin
    // R1: outputs stay at reset values while inputs toggle.
    driveWord(27'h7ff_ffff);
    #15;
    chk("R1 pixel", pixOut, 0);
    chk("R1 flags", {deOut, hsyncOut, vsyncOut, pixValid}, 0);
    #20;
    driveWord(27'h5a5_a5a5);
    #10;
    chk("R1 pixel held", pixOut, 0);
    chk("R1 flags held", {deOut, hsyncOut, vsyncOut, pixValid}, 0);
    // t = 45: release reset after a falling edge, drive word for edge k=1.
    rstN = 1'b1;
    driveRise(4'b1111, 1'b0);
    for (int cfg = 0; cfg < 16; cfg++) begin
      for (int c = 0; c < 50; c++) begin
        #10; k++;
        stepCycle(0);
        #10;
        driveRise(4'(cfg), ($urandom_range(5, 0) == 0));
      end
    end
    // R12: mode changes every cycle.
    for (int c = 0; c < 200; c++) begin
      #10; k++;
      stepCycle(0);
      #10;
      driveRise(4'($urandom()), ($urandom_range(7, 0) == 0));
    end
    #10; k++;
    stepCycle(1);
    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      nTests++;
      nFail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", nTests, nFail);
      $finish;
    end
  end

endmodule